// File: doc/BRIEF.md
# Data-Clock Phase Comparator with Baud Window

This block measures how far a recovered bit clock lags the start of each incoming one bit. It produces an "advance" (up) pulse and a "retard" (down) pulse whose widths carry the phase error. A downstream loop filter integrates the difference between the two widths and steers the clock source. The block runs on a fast oversampling system clock, and every width is a count of system-clock ticks. Both the serial data line and the recovered clock pass through two-stage synchronizers. Their rising edges are found by comparing each synchronized sample with the one before it.

Each data rising edge does three things: it sets a comparator flag, raises the up output, and launches a baud window of fixed length. The next rising edge of the recovered clock clears the flag. That same edge fires a narrow strobe and toggles a divided-by-two clock output. The down output covers the rest of the baud window after the clock edge. When the loop is locked, the up and down widths are equal. A zero bit has no data rising edge, so neither output pulses and the loop holds its frequency across the gap.

Top module: `bitphase_cmp`

## Requirements
- R1: With the data rising edge seen D ticks before the clock rising edge (D ≥ 1), `up_o` is high for exactly D consecutive system-clock cycles and then falls.
- R2: A data rising edge opens a baud window of WIN_TICKS cycles (default 43). `dn_o` is high while that window is open and the comparator is clear, so with D < WIN_TICKS its width is WIN_TICKS − D.
- R3: When the data and clock rising edges arrive in the same cycle, the comparator stays clear: `up_o` does not pulse and `dn_o` is high for the full WIN_TICKS cycles.
- R4: When the clock rising edge comes WIN_TICKS or more cycles after the data rising edge, `dn_o` never asserts and `up_o` stays high until that clock edge.
- R5: Clock edges with no data rising edge (a zero bit) produce no `up_o` and no `dn_o` cycle.
- R6: Every clock rising edge drives `strobe_o` high for exactly STROBE_TICKS cycles (default 12).
- R7: `half_clk_o` inverts once per clock rising edge and is otherwise unchanged.
- R8: A data rising edge that arrives while a window is open restarts the window from that edge, and the comparator is set again.
- R9: A synchronous active-high `rst` drives all four outputs to 0 at the next clock edge.
- R10: `up_o` and `dn_o` are never high in the same cycle.
- R11: An input rising edge reaches the outputs three system-clock edges after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 1 | Serial data; each one bit is a high pulse |
| rclk_i | input | 1 | Recovered bit clock from the oscillator |
| up_o | output | 1 | Advance pulse, from data start to clock edge |
| dn_o | output | 1 | Retard pulse, from clock edge to window end |
| strobe_o | output | 1 | Narrow strobe on each clock rising edge |
| half_clk_o | output | 1 | Recovered clock divided by two |

## Verification
A comparator flag stuck set would show at the ports in two ways: `up_o` would run past the clock edge, and `dn_o` would vanish in the very next cycle. A stuck-clear flag would instead move the whole window into `dn_o`. A window counter that is off by one changes the measured `dn_o` width by one tick, and the table sweep catches that in the first row where D < WIN_TICKS. Synchronizer depth errors move the up/down timing rather than their widths, so a separate check compares the first output cycle with the known three-edge latency.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    localparam int CH_DATA = 0;
    localparam int CH_RCLK = 1;
    localparam int N_CH    = 2;

    typedef struct packed {
        logic data_rise;
        logic rclk_rise;
    } bpc_edges_t;

endpackage

// File: rtl/bpc_sync.sv
module bpc_sync #(
    parameter int N_CH   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] async_i,
    output logic [N_CH-1:0] level_o,
    output logic [N_CH-1:0] rise_o
);

    localparam int CW = STAGES + 1;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [CW-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CW-2:0], async_i[g]};
        end

        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= chain_d;
        end

        assign level_o[g] = chain_q[STAGES-1];
        assign rise_o[g]  = chain_q[STAGES-1] & ~chain_q[STAGES];

        // R11: an edge indication lasts a single cycle
        assert_rise_single_R11: assert property (@(posedge clk) disable iff (rst)
            rise_o[g] |=> !rise_o[g]);
    end

endmodule

// File: rtl/bpc_oneshot.sv
module bpc_oneshot #(
    parameter int TICKS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic active_o
);

    localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } os_state_t;

    os_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = CW'(TICKS - 1);
        end else if (st_q.active) begin
            if (st_q.cnt == '0) st_d.active = 1'b0;
            else                st_d.cnt    = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active_o = st_q.active;

    // R2 / R6: the remaining count never exceeds the programmed length
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CW'(TICKS - 1));

    // R2 / R6: a pulse only begins after a trigger
    assert_start_on_fire_R2: assert property (@(posedge clk) disable iff (rst)
        !fire_i && !st_q.active |=> !st_q.active);

endmodule

// File: rtl/bpc_phase_core.sv
module bpc_phase_core
    import bpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bpc_edges_t edges_i,
    input  logic       win_active_i,
    output logic       up_o,
    output logic       dn_o,
    output logic       half_o
);

    typedef struct packed {
        logic cmp;
        logic half;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edges_i.rclk_rise) begin
            st_d.cmp  = 1'b0;
            st_d.half = ~st_q.half;
        end else if (edges_i.data_rise) begin
            st_d.cmp  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign up_o   = st_q.cmp;
    assign dn_o   = win_active_i & ~st_q.cmp;
    assign half_o = st_q.half;

    // R1: comparator is cleared only by a clock edge
    assert_clear_by_clock_R1: assert property (@(posedge clk) disable iff (rst)
        st_q.cmp && !edges_i.rclk_rise |=> st_q.cmp);

    // R1 / R5: comparator is set only by a data edge
    assert_set_by_data_R5: assert property (@(posedge clk) disable iff (rst)
        !st_q.cmp && !edges_i.data_rise |=> !st_q.cmp);

    // R7: divided clock holds between clock edges
    assert_half_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !edges_i.rclk_rise |=> $stable(st_q.half));

endmodule

// File: rtl/bitphase_cmp.sv
module bitphase_cmp
    import bpc_pkg::*;
#(
    parameter int WIN_TICKS    = 43,
    parameter int STROBE_TICKS = 12,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic data_i,
    input  logic rclk_i,
    output logic up_o,
    output logic dn_o,
    output logic strobe_o,
    output logic half_clk_o
);

    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] lvl;
    logic [N_CH-1:0] rise;
    bpc_edges_t      edges;
    logic            win_active;

    always_comb begin
        raw_in          = '0;
        raw_in[CH_DATA] = data_i;
        raw_in[CH_RCLK] = rclk_i;
        edges.data_rise = rise[CH_DATA];
        edges.rclk_rise = rise[CH_RCLK];
    end

    bpc_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_in),
        .level_o (lvl),
        .rise_o  (rise)
    );

    bpc_oneshot #(.TICKS(WIN_TICKS)) u_window (
        .clk      (clk),
        .rst      (rst),
        .fire_i   (edges.data_rise),
        .active_o (win_active)
    );

    bpc_oneshot #(.TICKS(STROBE_TICKS)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .fire_i   (edges.rclk_rise),
        .active_o (strobe_o)
    );

    bpc_phase_core u_core (
        .clk          (clk),
        .rst          (rst),
        .edges_i      (edges),
        .win_active_i (win_active),
        .up_o         (up_o),
        .dn_o         (dn_o),
        .half_o       (half_clk_o)
    );

    // R10: advance and retard never overlap
    assert_up_dn_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(up_o && dn_o));

    // R9: reset clears every output on the following edge
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> !up_o && !dn_o && !strobe_o && !half_clk_o);

    // R6: strobe starts only after a clock edge
    assert_strobe_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_o) |-> $past(edges.rclk_rise));

    logic unused_lvl;
    assign unused_lvl = ^lvl;

endmodule

// File: tb/bitphase_cmp_tb.sv
`timescale 1ns/1ps
module bitphase_cmp_tb;

    localparam int WIN = 43;
    localparam int STB = 12;
    localparam int NROW = 7;

    // stimulus: clock edge offset (ticks after data start); expected up / dn widths
    localparam int OFFS [NROW]   = '{1, 5, 20, 42, 43, 50, 0};
    localparam int EXP_UP [NROW] = '{1, 5, 20, 42, 43, 50, 0};
    localparam int EXP_DN [NROW] = '{42, 38, 23, 1, 0, 0, 43};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_i = 1'b0;
    logic rclk_i = 1'b0;
    logic up_o, dn_o, strobe_o, half_clk_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    bitphase_cmp #(.WIN_TICKS(WIN), .STROBE_TICKS(STB)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .data_i     (data_i),
        .rclk_i     (rclk_i),
        .up_o       (up_o),
        .dn_o       (dn_o),
        .strobe_o   (strobe_o),
        .half_clk_o (half_clk_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one scenario: data starts at d1 (and d2 if >= 0), clock edges at c1 (and c2 if >= 0)
    task automatic run_case(input int d1, input int d2, input int c1, input int c2,
                            input int n, output int up_w, output int dn_w,
                            output int st_w, output int tog, output int first_up);
        logic prev_half;
        up_w = 0; dn_w = 0; st_w = 0; tog = 0; first_up = -1;
        @(negedge clk);
        prev_half = half_clk_o;
        for (int c = 0; c < n; c++) begin
            if (up_o) begin
                up_w++;
                if (first_up < 0) first_up = c;
            end
            if (dn_o) dn_w++;
            if (strobe_o) st_w++;
            if (half_clk_o != prev_half) tog++;
            prev_half = half_clk_o;
            data_i = (d1 >= 0 && c >= d1 && c < d1 + 4) || (d2 >= 0 && c >= d2 && c < d2 + 4);
            rclk_i = (c1 >= 0 && c >= c1 && c < c1 + 4) || (c2 >= 0 && c >= c2 && c < c2 + 4);
            @(negedge clk);
        end
        data_i = 1'b0;
        rclk_i = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int uw, dw, sw, tg, fu;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9 reset up", up_o, 0);
        check("R9 reset dn", dn_o, 0);
        check("R9 reset strobe", strobe_o, 0);
        check("R9 reset half", half_clk_o, 0);

        // table sweep over phase offsets: R1 R2 R3 R4 R6 R7
        for (int i = 0; i < NROW; i++) begin
            run_case(0, -1, OFFS[i], -1, OFFS[i] + WIN + 20, uw, dw, sw, tg, fu);
            check($sformatf("R1 R4 up width off=%0d", OFFS[i]), uw, EXP_UP[i]);
            check($sformatf("R2 R3 dn width off=%0d", OFFS[i]), dw, EXP_DN[i]);
            check($sformatf("R6 strobe width off=%0d", OFFS[i]), sw, STB);
            check($sformatf("R7 half toggles off=%0d", OFFS[i]), tg, 1);
            if (i == 2) check("R11 latency first up cycle", fu, 3);
        end

        // R5: zero bits, clock only
        run_case(-1, -1, 5, 30, 70, uw, dw, sw, tg, fu);
        check("R5 zero bit up", uw, 0);
        check("R5 zero bit dn", dw, 0);
        check("R6 strobe two edges", sw, 2 * STB);
        check("R7 half two edges", tg, 2);

        // R8: second data start inside the window, clock after it
        run_case(0, 20, 30, -1, 110, uw, dw, sw, tg, fu);
        check("R8 restart up width", uw, 30);
        check("R8 restart dn width", dw, WIN + 20 - 30);

        // R9: reset in the middle of an up pulse
        @(negedge clk);
        data_i = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 up before reset", up_o, 1);
        rst = 1'b1;
        @(negedge clk);
        check("R9 up cleared", up_o, 0);
        check("R9 dn cleared", dn_o, 0);
        rst = 1'b0;
        data_i = 1'b0;
        repeat (WIN + 5) @(negedge clk);
        check("R10 idle up", up_o, 0);
        check("R10 idle dn", dn_o, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule